// File: doc/BRIEF.md
# Slow-Clock System Timer

This block is a system timer kept on the bus clock and paced by a 32768 Hz slow clock. It holds a free-running real-time counter with a programmable prescaler, an alarm that matches an absolute counter value, and a periodic interval timer. Each of these raises a flag in a status register. Reading the status register returns the pending flags and clears them. One interrupt line is driven from the flags that an enable mask lets through. Software changes the mask only through a write-one-to-set register and a write-one-to-clear register.

The slow clock comes in as a plain input. A two-flop synchroniser samples it on the bus clock, and each rising edge gives one single-cycle tick. All timer state then lives in the bus-clock domain, so a counter read always returns a whole, settled value. The bus port is a single-cycle register port. A write takes effect at the clock edge of the access. Read data is registered and is valid in the cycle after the access.

Register offsets (word index on `bus_addr`): 0 status, 1 mask set, 2 mask clear, 3 mask read, 4 interval, 5 prescaler, 6 alarm, 7 counter.

Top module: `slowclk_sys_timer`

## Requirements
- R1: The counter at offset 7 is CNT_W bits wide. It steps by exactly one on each increment and wraps from all ones to zero.
- R2: The prescaler at offset 5 makes the counter advance once every P slow ticks. P = 1 advances it on every tick, and a value of 0 stands for 2^PRE_W. The reset value is PRE_RST (32768, a 1 Hz rate). Writing the prescaler clears both the counter and the prescale phase.
- R3: The alarm at offset 6 holds an absolute counter value. Status bit 3 sets when the counter steps onto that value. If the alarm is written with the value the counter holds at that moment, the flag sets only after the counter has wrapped all the way around.
- R4: The interval timer at offset 4 sets status bit 0 once every V slow ticks, counted from the write of V, and repeats without end. V = 0 stops it, and V is 0 after reset.
- R5: Status bits are: bit 0 interval expiry, bit 1 watchdog overflow (always 0 here), bit 2 counter increment, bit 3 alarm. A read of offset 0 returns the pending bits and clears them.
- R6: A status event that occurs in the same cycle as a status read is kept, and the next read reports it.
- R7: A 1 written to a bit at offset 1 enables that mask bit. A 1 written to a bit at offset 2 disables it. A 0 bit in either write leaves the mask bit unchanged. The mask reads back at offset 3 and is all zero after reset.
- R8: `irq` is high exactly when some status bit is set and its mask bit is enabled.
- R9: Each rising edge of `slow_clk` gives exactly one tick. After reset the counter, status and mask are zero and the interval is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus/system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_clk | input | 1 | 32768 Hz slow clock, asynchronous to clk |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| irq | output | 1 | Interrupt request, level |

## Verification
The counter is swept over prescaler values 1 to 4 with a read after every slow pulse, so a phase error and an off-by-one division give different counts. The interval timer is swept over intervals 1 to 5 and over 0, which separates the first expiry from the reload period and from the stopped case. The alarm is tried once a few steps ahead and once at the current count, and the second case shows whether a full wrap of the 8-bit bench counter is needed. A status read is moved across every cycle offset around a tick, to catch an increment flag that is lost or counted twice when it lands together with the read.

// File: rtl/slowclk_timer_pkg.sv
package slowclk_timer_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 3;
    localparam int NSTAT  = 4;

    localparam logic [ADDR_W-1:0] OFF_STATUS = 3'd0;
    localparam logic [ADDR_W-1:0] OFF_MSET   = 3'd1;
    localparam logic [ADDR_W-1:0] OFF_MCLR   = 3'd2;
    localparam logic [ADDR_W-1:0] OFF_MASK   = 3'd3;
    localparam logic [ADDR_W-1:0] OFF_IVL    = 3'd4;
    localparam logic [ADDR_W-1:0] OFF_PRESC  = 3'd5;
    localparam logic [ADDR_W-1:0] OFF_ALARM  = 3'd6;
    localparam logic [ADDR_W-1:0] OFF_COUNT  = 3'd7;

    localparam int BIT_PIT = 0;
    localparam int BIT_WDG = 1;
    localparam int BIT_INC = 2;
    localparam int BIT_ALM = 3;
endpackage

// File: rtl/slowclk_tick_sync.sv
// Brings the slow clock into the bus clock domain and turns each rising
// edge into a one-cycle tick.
// Assumes clk runs more than twice as fast as slow_clk, so no edge is missed.
module slowclk_tick_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_in,
    output logic tick
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Metastability chain followed by a one-flop edge memory.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], slow_in};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign tick = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/slowclk_rtc.sv
// Holds the prescaled real-time counter and its absolute alarm.
// Assumes tick is a one-cycle pulse per slow-clock edge. A prescaler write
// restarts counting from zero. The alarm fires only on a step onto its value.
module slowclk_rtc #(
    parameter int CNT_W   = 20,
    parameter int PRE_W   = 16,
    parameter int PRE_RST = 32768
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             presc_wr,
    input  logic [PRE_W-1:0] presc_wdata,
    input  logic             alarm_wr,
    input  logic [CNT_W-1:0] alarm_wdata,
    output logic [CNT_W-1:0] count,
    output logic [PRE_W-1:0] presc,
    output logic [CNT_W-1:0] alarm,
    output logic             inc_evt,
    output logic             alm_evt
);
    localparam int PE_W = PRE_W + 1;

    logic [PRE_W-1:0] phase_q;
    logic [PE_W-1:0]  presc_eff;
    logic             last_phase;
    logic [CNT_W-1:0] cnt_nxt;

    // Zero in the prescaler stands for the full 2^PRE_W division.
    assign presc_eff  = (presc == '0) ? {1'b1, {PRE_W{1'b0}}} : {1'b0, presc};
    assign last_phase = (({1'b0, phase_q} + PE_W'(1)) == presc_eff);
    assign cnt_nxt    = count + CNT_W'(1);
    assign inc_evt    = tick & last_phase & ~presc_wr;
    assign alm_evt    = inc_evt & (cnt_nxt == alarm);

    // Prescale phase and counter advance; a prescaler write restarts both.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
            count   <= '0;
            presc   <= PRE_W'(PRE_RST);
        end else if (presc_wr) begin
            presc   <= presc_wdata;
            phase_q <= '0;
            count   <= '0;
        end else if (tick) begin
            if (last_phase) begin
                phase_q <= '0;
                count   <= cnt_nxt;
            end else begin
                phase_q <= phase_q + PRE_W'(1);
            end
        end
    end

    // Alarm register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            alarm <= '0;
        else if (alarm_wr)
            alarm <= alarm_wdata;
    end
endmodule

// File: rtl/slowclk_pit.sv
// Periodic interval timer: flags once every interval slow ticks, counted from
// the last interval write.
// Assumes an interval of zero means stopped, which is also the reset state.
module slowclk_pit #(
    parameter int PIT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ivl_wr,
    input  logic [PIT_W-1:0] ivl_wdata,
    output logic [PIT_W-1:0] interval,
    output logic             pit_evt
);
    logic [PIT_W-1:0] remain_q;
    logic             running;
    logic             expire;

    assign running = (interval != '0);
    assign expire  = (remain_q <= PIT_W'(1));
    assign pit_evt = tick & running & expire & ~ivl_wr;

    // Interval register and down-counter with automatic reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            interval <= '0;
            remain_q <= '0;
        end else if (ivl_wr) begin
            interval <= ivl_wdata;
            remain_q <= ivl_wdata;
        end else if (tick && running) begin
            remain_q <= expire ? interval : remain_q - PIT_W'(1);
        end
    end
endmodule

// File: rtl/slowclk_sys_timer.sv
// Top of the slow-clock system timer: register port, status flags that clear
// on read, interrupt mask and interrupt line.
// Assumes one-cycle bus accesses. Read data is registered and valid the cycle
// after the access. Events that land on a status read are kept.
module slowclk_sys_timer
    import slowclk_timer_pkg::*;
#(
    parameter int CNT_W       = 20,
    parameter int PRE_W       = 16,
    parameter int PIT_W       = 16,
    parameter int PRE_RST     = 32768,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_clk,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic             tick;
    logic             wr_en, rd_en;
    logic             rd_status, mset_wr, mclr_wr;
    logic             ivl_wr, presc_wr, alarm_wr;
    logic [CNT_W-1:0] count, alarm;
    logic [PRE_W-1:0] presc;
    logic [PIT_W-1:0] interval;
    logic             inc_evt, alm_evt, pit_evt;
    logic [NSTAT-1:0] evt, status, mask;
    logic [NSTAT-1:0] wbits;
    logic [DATA_W-1:0] rd_mux;
    logic             unused_wdata;

    assign wr_en     = bus_sel & bus_wr;
    assign rd_en     = bus_sel & ~bus_wr;
    assign rd_status = rd_en & (bus_addr == OFF_STATUS);
    assign mset_wr   = wr_en & (bus_addr == OFF_MSET);
    assign mclr_wr   = wr_en & (bus_addr == OFF_MCLR);
    assign ivl_wr    = wr_en & (bus_addr == OFF_IVL);
    assign presc_wr  = wr_en & (bus_addr == OFF_PRESC);
    assign alarm_wr  = wr_en & (bus_addr == OFF_ALARM);
    assign wbits     = bus_wdata[NSTAT-1:0];
    assign unused_wdata = ^bus_wdata;

    slowclk_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .slow_in (slow_clk),
        .tick    (tick)
    );

    slowclk_rtc #(.CNT_W(CNT_W), .PRE_W(PRE_W), .PRE_RST(PRE_RST)) u_rtc (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .presc_wr    (presc_wr),
        .presc_wdata (bus_wdata[PRE_W-1:0]),
        .alarm_wr    (alarm_wr),
        .alarm_wdata (bus_wdata[CNT_W-1:0]),
        .count       (count),
        .presc       (presc),
        .alarm       (alarm),
        .inc_evt     (inc_evt),
        .alm_evt     (alm_evt)
    );

    slowclk_pit #(.PIT_W(PIT_W)) u_pit (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .ivl_wr    (ivl_wr),
        .ivl_wdata (bus_wdata[PIT_W-1:0]),
        .interval  (interval),
        .pit_evt   (pit_evt)
    );

    // Gather events at their status bit positions; the watchdog bit stays idle.
    always_comb begin
        evt          = '0;
        evt[BIT_PIT] = pit_evt;
        evt[BIT_WDG] = 1'b0;
        evt[BIT_INC] = inc_evt;
        evt[BIT_ALM] = alm_evt;
    end

    // Status flags: a read clears, and new events win over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            status <= '0;
        else
            status <= (rd_status ? '0 : status) | evt;
    end

    // Interrupt mask, changed only through write-one set and clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask <= '0;
        else if (mset_wr)
            mask <= mask | wbits;
        else if (mclr_wr)
            mask <= mask & ~wbits;
    end

    // Read data selection by register offset.
    always_comb begin
        unique case (bus_addr)
            OFF_STATUS: rd_mux = DATA_W'(status);
            OFF_MASK:   rd_mux = DATA_W'(mask);
            OFF_IVL:    rd_mux = DATA_W'(interval);
            OFF_PRESC:  rd_mux = DATA_W'(presc);
            OFF_ALARM:  rd_mux = DATA_W'(alarm);
            OFF_COUNT:  rd_mux = DATA_W'(count);
            default:    rd_mux = '0;
        endcase
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (rd_en)
            bus_rdata <= rd_mux;
    end

    assign irq = |(status & mask);
endmodule

// File: rtl/slowclk_sys_timer_chk.sv
// Property checker for slowclk_sys_timer, attached through bind.
// Assumes it sees the top's internal status, mask and event signals.
module slowclk_sys_timer_chk #(
    parameter int CNT_W = 20,
    parameter int PIT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] alarm,
    input logic [PIT_W-1:0] interval,
    input logic [3:0]       status,
    input logic [3:0]       mask,
    input logic [3:0]       evt,
    input logic [3:0]       wbits,
    input logic             rd_status,
    input logic             mset_wr,
    input logic             mclr_wr,
    input logic             presc_wr,
    input logic             irq
);
    // R1
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((count != $past(count)) && !$past(presc_wr)) |-> (count == $past(count) + CNT_W'(1)));
    // R3
    alarm_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt[3] |=> (count == $past(alarm)));
    // R4
    pit_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (interval == '0) |-> !evt[0]);
    // R5
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_status |=> ((status & ~$past(evt)) == 4'b0));
    // R5
    wdg_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !status[1]);
    // R6
    rd_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && evt[2]) |=> status[2]);
    // R7
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mset_wr |=> ((mask & $past(wbits)) == $past(wbits)));
    // R7
    mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mclr_wr |=> ((mask & $past(wbits)) == 4'b0));
    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == 4'b0) |-> !irq);
endmodule

bind slowclk_sys_timer slowclk_sys_timer_chk #(.CNT_W(CNT_W), .PIT_W(PIT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .count     (count),
    .alarm     (alarm),
    .interval  (interval),
    .status    (status),
    .mask      (mask),
    .evt       (evt),
    .wbits     (wbits),
    .rd_status (rd_status),
    .mset_wr   (mset_wr),
    .mclr_wr   (mclr_wr),
    .presc_wr  (presc_wr),
    .irq       (irq)
);

// File: tb/slowclk_sys_timer_test.sv
module slowclk_sys_timer_test;
    localparam int CW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_clk = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic [31:0] rv, r1, r2;

    always #4 clk = ~clk;

    slowclk_sys_timer #(.CNT_W(CW)) uut (
        .clk (clk), .rst_n (rst_n), .slow_clk (slow_clk),
        .bus_sel (bus_sel), .bus_wr (bus_wr), .bus_addr (bus_addr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .irq (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); slow_clk = 1'b1;
            repeat (4) @(negedge clk);
            slow_clk = 1'b0;
            repeat (4) @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run did not complete, got hang expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state (R9, R2, R4, R7, R8)
        rd(3'd7, rv); check("R9 counter after reset", rv, 0);
        rd(3'd0, rv); check("R9 status after reset", rv, 0);
        rd(3'd3, rv); check("R7 mask after reset", rv, 0);
        rd(3'd4, rv); check("R4 interval after reset", rv, 0);
        rd(3'd5, rv); check("R2 prescaler reset value", rv, 32768);
        check("R8 irq after reset", {31'b0, irq}, 0);
        pulse(3);
        rd(3'd7, rv); check("R2 slow rate holds counter", rv, 0);
        rd(3'd0, rv); check("R4 stopped interval timer, no flag", rv & 32'h1, 0);

        // Prescaler sweep (R1, R2, R9)
        for (int p = 1; p <= 4; p++) begin
            wr(3'd5, p);
            rd(3'd7, rv); check("R2 prescaler write clears counter", rv, 0);
            for (int n = 1; n <= 12; n++) begin
                pulse(1);
                rd(3'd7, rv); check("R2/R9 counter vs pulses", rv, n / p);
            end
        end

        // Wrap (R1)
        wr(3'd5, 1);
        pulse(255);
        rd(3'd7, rv); check("R1 counter at all ones", rv, 255);
        pulse(1);
        rd(3'd7, rv); check("R1 counter wraps to zero", rv, 0);
        pulse(4);
        rd(3'd7, rv); check("R1 counter after wrap", rv, 4);

        // Alarm (R3, R5)
        wr(3'd5, 1);
        pulse(10);
        rd(3'd0, rv);
        rd(3'd0, rv); check("R5 second status read is clear", rv, 0);
        wr(3'd6, 13);
        pulse(2);
        rd(3'd0, rv); check("R3 alarm not yet reached", rv & 32'h8, 0);
        check("R5 increment flag set", rv & 32'h4, 32'h4);
        pulse(1);
        rd(3'd0, rv); check("R3 alarm on match", rv & 32'h8, 32'h8);
        rd(3'd7, rv); check("R3 counter at alarm", rv, 13);
        wr(3'd6, 13);
        pulse(255);
        rd(3'd0, rv); check("R3 alarm at current count waits for wrap", rv & 32'h8, 0);
        pulse(1);
        rd(3'd0, rv); check("R3 alarm after full wrap", rv & 32'h8, 32'h8);
        check("R5 watchdog bit idle", rv & 32'h2, 0);

        // Interval timer sweep (R4)
        for (int v = 1; v <= 5; v++) begin
            wr(3'd4, v);
            rd(3'd0, rv);
            for (int n = 1; n <= 12; n++) begin
                pulse(1);
                rd(3'd0, rv);
                check("R4 interval flag cadence", rv & 32'h1, ((n % v) == 0) ? 1 : 0);
            end
        end
        wr(3'd4, 0);
        rd(3'd0, rv);
        for (int n = 1; n <= 10; n++) begin
            pulse(1);
            rd(3'd0, rv); check("R4 interval zero stops flags", rv & 32'h1, 0);
        end

        // Read colliding with an increment (R6)
        wr(3'd5, 1);
        for (int k = 0; k <= 6; k++) begin
            rd(3'd0, rv);
            @(negedge clk); slow_clk = 1'b1;
            repeat (k) @(negedge clk);
            rd(3'd0, r1);
            repeat (8) @(negedge clk);
            slow_clk = 1'b0;
            repeat (4) @(negedge clk);
            rd(3'd0, r2);
            check("R6 increment reported exactly once", {31'b0, r1[2]} + {31'b0, r2[2]}, 1);
        end

        // Mask writes (R7)
        wr(3'd1, 32'h5);
        rd(3'd3, rv); check("R7 set bits 0 and 2", rv, 32'h5);
        wr(3'd1, 32'h0);
        rd(3'd3, rv); check("R7 zero write to set register no effect", rv, 32'h5);
        wr(3'd2, 32'h1);
        rd(3'd3, rv); check("R7 clear bit 0", rv, 32'h4);
        wr(3'd2, 32'h0);
        rd(3'd3, rv); check("R7 zero write to clear register no effect", rv, 32'h4);
        wr(3'd1, 32'h8);
        rd(3'd3, rv); check("R7 set bit 3 keeps bit 2", rv, 32'hC);

        // Interrupt line (R8)
        wr(3'd2, 32'hF);
        wr(3'd1, 32'h4);
        rd(3'd0, rv);
        @(negedge clk); check("R8 irq low with no status", {31'b0, irq}, 0);
        pulse(1);
        check("R8 irq on enabled increment", {31'b0, irq}, 1);
        rd(3'd0, rv);
        @(negedge clk); check("R8 irq drops after status read", {31'b0, irq}, 0);
        wr(3'd2, 32'h4);
        pulse(1);
        check("R8 irq masked off", {31'b0, irq}, 0);
        wr(3'd1, 32'h4);
        @(negedge clk); check("R8 irq on enabling pending flag", {31'b0, irq}, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule